// File: doc/BRIEF.md
# Two-Image Crossfade Blend Pipeline

This block blends two pixel streams into one. Each output pixel is a weighted average of the matching pixels from source A and source B, `w*a + (1-w)*b`. Pixels are unsigned 8-bit values. Each bus beat carries two pixels packed into a halfword. A single 16-bit fixed-point weight controls the mix, and the weight for source B is derived inside the block as its complement.

A frame begins with a pulse on `frameStart` that carries the new weight. The weight is loaded only when no beats are in flight. Sweeping the weight from frame to frame produces a fade from one image to the other.

Data moves through a three-stage pipeline: multiply, sum, then clamp and pack. Valid/ready handshakes on both the input and output sides let a slow consumer stall the whole pipeline without losing or repeating a beat.

Top module: `xfade_top`

## Requirements
- R1: Each 16-bit data bus holds two independent pixel lanes: lane 0 in bits [7:0] and lane 1 in bits [15:8]. A lane's result depends only on the same lane of `inA` and `inB`.
- R2: With `wh` equal to bits [15:8] of the loaded weight, each output pixel is `floor((wh*a + (255-wh)*b) / 256)`. The value `255-wh` is the upper byte of `0xFFFF` minus the weight. Bits [7:0] of the weight have no effect.
- R3: A weight of 0x8080 gives an even mix. For a=b=0xFF the output is 0xFE, and for a=0x80, b=0x00 the output is 0x40.
- R4: Each lane sum is formed at 17 bits and clamps to 0xFF if bit 16 is set. With complementary weights that bit never sets, so results never wrap.
- R5: With `outReady` held high, a beat accepted at a clock edge appears on `outData` with `outValid` high after the third edge, counting the accepting edge. The block accepts one beat per cycle with no bubbles.
- R6: While `outValid` is high and `outReady` is low, `outValid` and `outData` hold. Once the last stage is full and stalled, `inReady` drops: exactly three beats are absorbed. Beats leave in arrival order, with none lost or duplicated.
- R7: `frameStart` loads `weightIn` at the clock edge only if no beat is in any pipeline stage. A pulse while beats are in flight is ignored, and the old weight stays in effect.
- R8: After reset, `outValid` is 0, `inReady` is 1, and the weight is 0x0000, so each output pixel equals `floor(255*b/256)`.
- R9: A weight with upper byte 0xFF gives `floor(255*a/256)`, and one with upper byte 0x00 gives `floor(255*b/256)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Request to load `weightIn` as the frame weight |
| weightIn | input | 16 | Fixed-point weight for source A |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Block can accept an input beat |
| inA | input | 16 | Two packed pixels from source A |
| inB | input | 16 | Two packed pixels from source B |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Consumer accepts the output beat |
| outData | output | 16 | Two packed blended pixels |

## Verification
The bench uses the weight extremes 0x00xx and 0xFFxx, where a design that forms the complement as `256-wh` or uses the full weight would get the end pixels wrong. It also sends 0x4000 and 0x40FF with the same data, which exposes any leak of the low weight byte into the result.

A `frameStart` is pulsed while a beat is in flight. A design that loads the weight regardless would blend that beat, or the next one, with the wrong weight.

Streams run with steady, periodic and fully blocked backpressure. A stall that is mishandled shows up as a changed held output, more than three absorbed beats, a dropped or doubled pixel pair, or a wrong bubble count.

// File: rtl/xfade_pkg.sv
package xfade_pkg;
  // Pipeline depth: multiply, sum, clamp/pack
  localparam int STAGES = 3;

  typedef struct packed {
    logic advance;     // all stages shift this cycle
    logic loadWeight;  // capture weightIn into the weight register
  } stageCtl_t;
endpackage

// File: rtl/xfade_ctrl.sv
module xfade_ctrl
  import xfade_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frameStart,
  input  logic      inValid,
  input  logic      outReady,
  output logic      inReady,
  output logic      outValid,
  output stageCtl_t ctl
);
  logic [STAGES-1:0] vPipe;
  logic pipeEmpty;

  assign pipeEmpty      = ~|vPipe;
  assign ctl.advance    = ~vPipe[STAGES-1] | outReady;
  assign ctl.loadWeight = frameStart & pipeEmpty;
  assign inReady        = ctl.advance;
  assign outValid       = vPipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vPipe <= '0;
    end else if (ctl.advance) begin
      vPipe <= {vPipe[STAGES-2:0], inValid};
    end
  end

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid);

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && $past(outReady) && $past(outReady, 2) && $past(outReady, 3)
      |-> $past(inValid, 3));
endmodule

// File: rtl/xfade_datapath.sv
module xfade_datapath
  import xfade_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 2,
  parameter int W_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  stageCtl_t              ctl,
  input  logic [W_W-1:0]         weightIn,
  input  logic [LANES*PIX_W-1:0] inA,
  input  logic [LANES*PIX_W-1:0] inB,
  output logic [LANES*PIX_W-1:0] outData
);
  localparam int PROD_W = 2 * PIX_W;
  localparam int SUM_W  = PROD_W + 1;

  logic [W_W-1:0]   weightReg;
  logic [PIX_W-1:0] wHi;
  logic [PIX_W-1:0] compHi;
  logic [W_W-1:0]   weightComp;

  always_ff @(posedge clk) begin
    if (!rst_n)              weightReg <= '0;
    else if (ctl.loadWeight) weightReg <= weightIn;
  end

  assign weightComp = {W_W{1'b1}} - weightReg;
  assign wHi        = weightReg[W_W-1 -: PIX_W];
  assign compHi     = weightComp[W_W-1 -: PIX_W];

  logic unusedLowWeight;
  assign unusedLowWeight = ^{weightReg[W_W-PIX_W-1:0], weightComp[W_W-PIX_W-1:0]};

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [PIX_W-1:0]  pixA, pixB;
    logic [PROD_W-1:0] prodA, prodB;
    logic [SUM_W-1:0]  sumQ;
    logic [PIX_W-1:0]  pixOut;

    assign pixA = inA[ln*PIX_W +: PIX_W];
    assign pixB = inB[ln*PIX_W +: PIX_W];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prodA  <= '0;
        prodB  <= '0;
        sumQ   <= '0;
        pixOut <= '0;
      end else if (ctl.advance) begin
        prodA  <= PROD_W'(wHi) * PROD_W'(pixA);
        prodB  <= PROD_W'(compHi) * PROD_W'(pixB);
        sumQ   <= {1'b0, prodA} + {1'b0, prodB};
        pixOut <= sumQ[SUM_W-1] ? {PIX_W{1'b1}} : sumQ[PROD_W-1 -: PIX_W];
      end
    end

    assign outData[ln*PIX_W +: PIX_W] = pixOut;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sumQ[SUM_W-1]);
  end
endmodule

// File: rtl/xfade_top.sv
module xfade_top
  import xfade_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frameStart,
  input  logic [15:0] weightIn,
  input  logic        inValid,
  output logic        inReady,
  input  logic [15:0] inA,
  input  logic [15:0] inB,
  output logic        outValid,
  input  logic        outReady,
  output logic [15:0] outData
);
  stageCtl_t ctl;

  xfade_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frameStart (frameStart),
    .inValid    (inValid),
    .outReady   (outReady),
    .inReady    (inReady),
    .outValid   (outValid),
    .ctl        (ctl)
  );

  xfade_datapath #(.PIX_W(8), .LANES(2), .W_W(16)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .weightIn (weightIn),
    .inA      (inA),
    .inB      (inB),
    .outData  (outData)
  );

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> $stable(outData));
endmodule

// File: tb/tb_xfade_top.sv
module tb_xfade_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frameStart = 1'b0;
  logic [15:0] weightIn = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inA = '0;
  logic [15:0] inB = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [15:0] outData;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  xfade_top dut (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .weightIn(weightIn),
    .inValid(inValid), .inReady(inReady), .inA(inA), .inB(inB),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  // weight, a, b, expected
  localparam int NVEC = 8;
  localparam logic [63:0] VEC [NVEC] = '{
    {16'h8080, 16'hFF80, 16'hFF00, 16'hFE40},  // R3, R1
    {16'hFF00, 16'hFFFF, 16'h0000, 16'hFEFE},  // R9, R4
    {16'h0000, 16'hFFFF, 16'hFF10, 16'hFE0F},  // R9
    {16'h40FF, 16'h2080, 16'h6010, 16'h4F2B},  // R2
    {16'h4000, 16'h2080, 16'h6010, 16'h4F2B},  // R2 low byte ignored
    {16'hC000, 16'h0A64, 16'hC8FA, 16'h3888},  // R2, R1
    {16'h0100, 16'h00FF, 16'hFF00, 16'hFD00},  // R4, R1
    {16'hFFFF, 16'h7F01, 16'h80FE, 16'h7E00}   // R9
  };

  function automatic string vecTag(int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R9";
      3: return "R2";
      4: return "R2";
      5: return "R1";
      6: return "R4";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [15:0] blendModel(logic [15:0] w, logic [15:0] a, logic [15:0] b);
    logic [15:0] r;
    for (int ln = 0; ln < 2; ln++) begin
      int s;
      s = int'(w[15:8]) * int'(a[ln*8 +: 8]) + (255 - int'(w[15:8])) * int'(b[ln*8 +: 8]);
      r[ln*8 +: 8] = (s > 65535) ? 8'hFF : 8'(s / 256);
    end
    return r;
  endfunction

  function automatic logic [15:0] beatA(int k);
    return {8'(k * 37 + 5), 8'(k * 91 + 200)};
  endfunction

  function automatic logic [15:0] beatB(int k);
    return {8'(k * 53 + 17), 8'(255 - k * 29)};
  endfunction

  task automatic expectEq(input logic [15:0] act, input logic [15:0] exp, input string req);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadW(input logic [15:0] w);
    frameStart = 1'b1;
    weightIn = w;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // drive one beat at a negedge; check the three-cycle latency and the data
  task automatic sendBeatCheck(input logic [15:0] a, input logic [15:0] b,
                               input logic [15:0] exp, input string req);
    inA = a; inB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    expectEq(16'(outValid), 16'h0, "R5 early valid");
    @(negedge clk);
    expectEq(16'(outValid), 16'h1, "R5 valid at third edge");
    expectEq(outData, exp, req);
    @(negedge clk);
    expectEq(16'(outValid), 16'h0, "R5 single beat");
  endtask

  // pattern 0: always ready; 1: ready two of three cycles; 2: blocked six cycles
  task automatic runStream(input int n, input int pattern, input logic [15:0] w);
    int sent = 0;
    int got = 0;
    int cyc = 0;
    logic holdPend = 1'b0;
    logic [15:0] holdData = '0;
    while (got < n && cyc < 300) begin
      case (pattern)
        0: outReady = 1'b1;
        1: outReady = (cyc % 3) != 2;
        default: outReady = cyc >= 6;
      endcase
      inValid = sent < n;
      inA = beatA(sent);
      inB = beatB(sent);
      #1;
      if (holdPend) begin
        expectEq(16'(outValid), 16'h1, "R6 valid held");
        expectEq(outData, holdData, "R6 data held");
      end
      holdPend = outValid && !outReady;
      holdData = outData;
      if (pattern == 0 && sent < n) expectEq(16'(inReady), 16'h1, "R5 no bubble");
      if (pattern == 2 && cyc == 5) begin
        expectEq(16'(sent), 16'd3, "R6 absorbed beats");
        expectEq(16'(inReady), 16'h0, "R6 inReady low");
      end
      if (outValid && outReady) begin
        expectEq(outData, blendModel(w, beatA(got), beatB(got)), "R6 order");
        got++;
      end
      if (inValid && inReady) sent++;
      @(negedge clk);
      cyc++;
    end
    inValid = 1'b0;
    outReady = 1'b1;
    expectEq(16'(got), 16'(n), "R6 beat count");
    if (pattern == 0) expectEq(16'(cyc), 16'(n + 3), "R5 stream length");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    expectEq(16'(outValid), 16'h0, "R8 outValid");
    expectEq(16'(inReady), 16'h1, "R8 inReady");
    sendBeatCheck(16'h0000, 16'hFF80, 16'hFE7F, "R8 reset weight");

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      loadW(VEC[i][63:48]);
      sendBeatCheck(VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], vecTag(i));
      expectEq(blendModel(VEC[i][63:48], VEC[i][47:32], VEC[i][31:16]), VEC[i][15:0], "R2 model");
    end

    // R7: frameStart while a beat is in flight is ignored
    loadW(16'hFF00);
    inA = 16'h2040; inB = 16'h8000; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; frameStart = 1'b1; weightIn = 16'h0000;
    @(negedge clk);
    frameStart = 1'b0;
    @(negedge clk);
    expectEq(16'(outValid), 16'h1, "R7 in-flight valid");
    expectEq(outData, blendModel(16'hFF00, 16'h2040, 16'h8000), "R7 in-flight beat");
    @(negedge clk);
    sendBeatCheck(16'h2040, 16'h8000, blendModel(16'hFF00, 16'h2040, 16'h8000), "R7 weight kept");

    // R5 / R6 streams
    loadW(16'h6000);
    runStream(8, 0, 16'h6000);
    loadW(16'hA7C3);
    runStream(9, 1, 16'hA7C3);
    loadW(16'h3355);
    runStream(7, 2, 16'h3355);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule